// File: doc/BRIEF.md
# Driver Fault Deglitch and Auto-Retry Controller

This block supervises a bank of low-side power switches. Each switch has an overcurrent flag. A flag must stay high for a qualification window before that switch is latched off. The switch then stays off for a hold-off interval, after which it is released with no outside help. A die over-temperature flag and a supply undervoltage flag act on all switches at once. Neither of them latches. Over-temperature blocks the outputs and the step input for as long as it is present. Undervoltage also resets the surrounding logic and erases any overcurrent history.

Both durations are parameters counted in clock cycles. Each channel has its own persistence counter and its own hold-off counter, so a fault on one switch never delays or shortens the timing of another. The block produces four kinds of output: per-channel disables, an active-low fault indication, a step-block level for the indexer, and a logic-reset request. All of them come from registered state, and each input is seen at the outputs one clock edge after it is sampled.

Top module: `drv_fault_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released with no flag raised, every `drv_off_o` bit is 0, `fault_n_o` is 1, `step_block_o` is 0 and `logic_rst_o` is 0.
- R2: Channel i is latched off (`drv_off_o[i]`=1) after `oc_flag_i[i]` has been sampled high on DEGLITCH_CYC consecutive rising edges. The output changes right after the last of those edges.
- R3: If `oc_flag_i[i]` is sampled low after fewer than DEGLITCH_CYC high samples, the channel's persistence count is cleared. Such a pulse has no effect, and a later trip needs a fresh full run of high samples.
- R4: A tripped channel stays off for exactly RETRY_CYC cycles and is then released on its own. Its overcurrent flag is ignored while it is off. After release, a new trip again needs DEGLITCH_CYC consecutive high samples.
- R5: Channels time independently: each has its own persistence and hold-off count.
- R6: `fault_n_o` is 0 exactly while some channel is tripped or the registered over-temperature flag is set. Undervoltage alone leaves it at 1.
- R7: `step_block_o` is 1 whenever any channel is tripped, or over-temperature or undervoltage is active.
- R8: Over-temperature sampled high sets every `drv_off_o` bit on the next cycle. All bits are released once it is sampled low. It does not clear or restart overcurrent trips.
- R9: Undervoltage sampled high sets every `drv_off_o` bit and `logic_rst_o` on the next cycle. It also clears all trips and persistence counts.
- R10: `logic_reset_i` sampled high clears all trips and counts at once, without waiting for the hold-off to end. It drives `logic_rst_o` on the next cycle, and overcurrent flags are ignored while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| logic_reset_i | input | 1 | Synchronous logic reset request, active high |
| oc_flag_i | input | NUM_CH | Per-channel overcurrent flags |
| ot_flag_i | input | 1 | Die over-temperature flag |
| uv_flag_i | input | 1 | Supply undervoltage flag |
| drv_off_o | output | NUM_CH | Per-channel driver disable |
| fault_n_o | output | 1 | Fault indication, active low |
| step_block_o | output | 1 | Ignore step requests while high |
| logic_rst_o | output | 1 | Reset request to the surrounding logic |

## Verification
The assertions assume that the flags are already synchronous to `clk` and change only between edges. They also assume that over-temperature and undervoltage drive every output themselves, so a channel bit may rise without an overcurrent history only when one of those two was sampled. The bench drives every input on the falling edge. It holds each flag for whole cycles, and it checks the persistence window only in stretches where neither global flag is raised, so the run-length counter in the checker tracks exactly what the design samples.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

    // Registered global conditions shared by all channels.
    typedef struct packed {
        logic ot;
        logic uv;
        logic lrst;
    } sys_flags_t;

endpackage

// File: rtl/drv_sys_monitor.sv
module drv_sys_monitor
    import drv_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ot_i,
    input  logic       uv_i,
    input  logic       lrst_i,
    output sys_flags_t flags_o
);

    sys_flags_t flags_d, flags_q;

    always_comb begin
        flags_d      = flags_q;
        flags_d.ot   = ot_i;
        flags_d.uv   = uv_i;
        flags_d.lrst = lrst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/drv_oc_channel.sv
module drv_oc_channel #(
    parameter int unsigned DEGLITCH_CYC = 875,
    parameter int unsigned RETRY_CYC    = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic oc_i,
    output logic trip_o
);

    localparam int unsigned DG_W = (DEGLITCH_CYC > 1) ? $clog2(DEGLITCH_CYC) : 1;
    localparam int unsigned RT_W = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
    localparam logic [DG_W-1:0] DG_LAST = DG_W'(DEGLITCH_CYC - 1);
    localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_CYC - 1);

    typedef struct packed {
        logic            trip;
        logic [DG_W-1:0] dg_cnt;
        logic [RT_W-1:0] rt_cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (st_q.trip) begin
            // Hold-off: flag ignored, persistence count held at zero.
            st_d.dg_cnt = '0;
            if (st_q.rt_cnt == RT_LAST) begin
                st_d.trip   = 1'b0;
                st_d.rt_cnt = '0;
            end else begin
                st_d.rt_cnt = st_q.rt_cnt + 1'b1;
            end
        end else if (oc_i) begin
            if (st_q.dg_cnt == DG_LAST) begin
                st_d.trip   = 1'b1;
                st_d.dg_cnt = '0;
                st_d.rt_cnt = '0;
            end else begin
                st_d.dg_cnt = st_q.dg_cnt + 1'b1;
            end
        end else begin
            st_d.dg_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o = st_q.trip;

endmodule

// File: rtl/drv_fault_guard.sv
module drv_fault_guard
    import drv_fault_pkg::*;
#(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned DEGLITCH_CYC = 875,
    parameter int unsigned RETRY_CYC    = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              logic_reset_i,
    input  logic [NUM_CH-1:0] oc_flag_i,
    input  logic              ot_flag_i,
    input  logic              uv_flag_i,
    output logic [NUM_CH-1:0] drv_off_o,
    output logic              fault_n_o,
    output logic              step_block_o,
    output logic              logic_rst_o
);

    sys_flags_t        sys_q;
    logic [NUM_CH-1:0] trip_q;
    logic              chan_clear;

    // Undervoltage and the logic reset wipe all channel history.
    assign chan_clear = uv_flag_i | logic_reset_i;

    drv_sys_monitor u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .ot_i    (ot_flag_i),
        .uv_i    (uv_flag_i),
        .lrst_i  (logic_reset_i),
        .flags_o (sys_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        drv_oc_channel #(
            .DEGLITCH_CYC (DEGLITCH_CYC),
            .RETRY_CYC    (RETRY_CYC)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (chan_clear),
            .oc_i    (oc_flag_i[g]),
            .trip_o  (trip_q[g])
        );
    end

    always_comb begin
        drv_off_o    = trip_q | {NUM_CH{sys_q.ot | sys_q.uv}};
        fault_n_o    = ~((|trip_q) | sys_q.ot);
        step_block_o = (|trip_q) | sys_q.ot | sys_q.uv;
        logic_rst_o  = sys_q.uv | sys_q.lrst;
    end

endmodule

// File: rtl/drv_fault_guard_chk.sv
module drv_fault_guard_chk #(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned DEGLITCH_CYC = 875,
    parameter int unsigned RETRY_CYC    = 300000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              logic_reset_i,
    input logic [NUM_CH-1:0] oc_flag_i,
    input logic              ot_flag_i,
    input logic              uv_flag_i,
    input logic [NUM_CH-1:0] drv_off_o,
    input logic              fault_n_o,
    input logic              step_block_o,
    input logic              logic_rst_o
);

    localparam int unsigned RUN_W = $clog2(DEGLITCH_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEGLITCH_CYC);

    AST_OT_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag_i |=> (!fault_n_o && step_block_o && (&drv_off_o))); // R8

    AST_UV_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag_i |=> ((&drv_off_o) && logic_rst_o && step_block_o)); // R9

    AST_LRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_reset_i && !uv_flag_i && !ot_flag_i) |=>
        (drv_off_o == '0 && fault_n_o && logic_rst_o)); // R10

    AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> $past(ot_flag_i || (|oc_flag_i))); // R6

    for (genvar g = 0; g < NUM_CH; g++) begin : g_run
        logic [RUN_W-1:0] run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (logic_reset_i || uv_flag_i || !oc_flag_i[g]) begin
                run_q <= '0;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end

        AST_TRIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_off_o[g]) |-> $past(oc_flag_i[g] || ot_flag_i || uv_flag_i)); // R2

        AST_DEGLITCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(drv_off_o[g]) && !$past(ot_flag_i) && !$past(uv_flag_i)) |->
            (run_q == RUN_MAX)); // R3
    end

endmodule

bind drv_fault_guard drv_fault_guard_chk #(
    .NUM_CH       (NUM_CH),
    .DEGLITCH_CYC (DEGLITCH_CYC),
    .RETRY_CYC    (RETRY_CYC)
) u_chk (.*);

// File: tb/test_drv_fault_guard.sv
module test_drv_fault_guard;

    localparam int NCH = 4;
    localparam int DG  = 4;
    localparam int RT  = 10;
    localparam int NV  = 22;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lrst = 1'b0;
    logic [NCH-1:0] oc = '0;
    logic           ot = 1'b0;
    logic           uv = 1'b0;
    logic [NCH-1:0] off;
    logic           fault_n, sblk, lrst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    drv_fault_guard #(.NUM_CH(NCH), .DEGLITCH_CYC(DG), .RETRY_CYC(RT)) i_drv_fault_guard (
        .clk (clk), .rst_n (rst_n), .logic_reset_i (lrst), .oc_flag_i (oc),
        .ot_flag_i (ot), .uv_flag_i (uv), .drv_off_o (off), .fault_n_o (fault_n),
        .step_block_o (sblk), .logic_rst_o (lrst_o)
    );

    // Vector: [13:10] oc, [9] ot, [8] uv, [7] lrst | expected [6:3] off, [2] fault_n, [1] step_block, [0] logic_rst
    localparam logic [13:0] VEC [NV] = '{
        {4'b0001, 3'b000, 4'b0000, 3'b100},
        {4'b0001, 3'b000, 4'b0000, 3'b100},
        {4'b0001, 3'b000, 4'b0000, 3'b100},
        {4'b0000, 3'b000, 4'b0000, 3'b100},
        {4'b0011, 3'b000, 4'b0000, 3'b100},
        {4'b0011, 3'b000, 4'b0000, 3'b100},
        {4'b0011, 3'b000, 4'b0000, 3'b100},
        {4'b0001, 3'b000, 4'b0001, 3'b010},
        {4'b0010, 3'b000, 4'b0001, 3'b010},
        {4'b0010, 3'b000, 4'b0001, 3'b010},
        {4'b0010, 3'b000, 4'b0001, 3'b010},
        {4'b0010, 3'b000, 4'b0011, 3'b010},
        {4'b0000, 3'b100, 4'b1111, 3'b010},
        {4'b0000, 3'b000, 4'b0011, 3'b010},
        {4'b0000, 3'b000, 4'b0011, 3'b010},
        {4'b0000, 3'b000, 4'b0011, 3'b010},
        {4'b0000, 3'b000, 4'b0011, 3'b010},
        {4'b0000, 3'b000, 4'b0010, 3'b010},
        {4'b0000, 3'b000, 4'b0010, 3'b010},
        {4'b0000, 3'b000, 4'b0010, 3'b010},
        {4'b0000, 3'b000, 4'b0010, 3'b010},
        {4'b0000, 3'b000, 4'b0000, 3'b100}
    };

    function automatic logic [6:0] obs();
        return {off, fault_n, sblk, lrst_o};
    endfunction

    task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", obs(), 7'b0000_100);
        rst_n = 1'b1;
        step();
        chk("R1 after release", obs(), 7'b0000_100);

        // Vector table: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            oc = VEC[v][13:10]; ot = VEC[v][9]; uv = VEC[v][8]; lrst = VEC[v][7];
            step();
            chk($sformatf("table R2 R3 R5 R6 R7 R8 vec %0d", v), obs(), VEC[v][6:0]);
        end

        // R4: hold-off length exact, flag ignored during it, fresh window after release
        oc = 4'b0100;
        for (int k = 1; k < DG; k++) begin step(); chk("R4 qualify", obs(), 7'b0000_100); end
        step(); chk("R4 trip", obs(), 7'b0100_010);
        for (int k = 1; k < RT; k++) begin step(); chk("R4 hold-off", obs(), 7'b0100_010); end
        step(); chk("R4 released", obs(), 7'b0000_100);
        for (int k = 1; k < DG; k++) begin step(); chk("R4 requalify", obs(), 7'b0000_100); end
        step(); chk("R4 retrip", obs(), 7'b0100_010);

        // R10: logic reset clears the trip at once and masks flags while held
        lrst = 1'b1;
        step(); chk("R10 clear", obs(), 7'b0000_101);
        step(); chk("R10 held", obs(), 7'b0000_101);
        lrst = 1'b0;
        for (int k = 1; k < DG; k++) begin step(); chk("R10 count fresh", obs(), 7'b0000_100); end
        step(); chk("R10 retrip", obs(), 7'b0100_010);
        oc = '0; lrst = 1'b1; step(); lrst = 1'b0; step();

        // R9: undervoltage disables all, no fault_n, clears trips
        oc = 4'b1000;
        repeat (DG) step();
        chk("R9 pre trip", obs(), 7'b1000_010);
        oc = '0; uv = 1'b1;
        step(); chk("R9 R6 uv active", obs(), 7'b1111_111);
        uv = 1'b0;
        step(); chk("R9 trip cleared", obs(), 7'b0000_100);

        // R9: undervoltage also clears a partial persistence count
        oc = 4'b0001;
        repeat (DG - 1) step();
        uv = 1'b1;
        step(); chk("R9 uv mid count", obs(), 7'b1111_111);
        uv = 1'b0;
        for (int k = 1; k < DG; k++) begin step(); chk("R9 count restarted", obs(), 7'b0000_100); end
        step(); chk("R9 trip after fresh window", obs(), 7'b0001_010);

        // R1: power-up reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", obs(), 7'b0000_100);
        oc = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", obs(), 7'b0000_100);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule